// File: doc/BRIEF.md
# MSI Interrupt Latching Wrapper

This block sits between a PCIe controller core and the system interrupt controller. The core reports message-signalled interrupt activity as one-cycle set pulses, one pulse line per vector. The wrapper keeps those pulses in a per-vector status register that software clears bit by bit. All vector activity is folded into one latched MSI summary bit of a wrapper status register. The same register holds one latched bit per legacy INTx line. A single interrupt output is the OR of the enabled wrapper status bits.

The MSI summary latch is edge-armed. Once it has latched, new vector activity cannot raise it again until software reads the per-vector register and that read returns zero. The intended service routine is:

1. Read the wrapper status.
2. Clear the wrapper status by writing back the value just read.
3. Read the vector register, clear the bits that were set, and repeat until a read returns zero.

That zero read re-arms the latch. The next vector that is set after it raises the summary bit and the interrupt again.

Top module: `msi_latch_wrap`

## Requirements
- R1: A 1 on `vec_set[i]` in a cycle sets bit i of the vector register (`reg_addr` = 1). The bit stays set until software clears it.
- R2: Writing `reg_addr` = 1 clears every vector bit whose `reg_wdata` bit is 1 and leaves the other bits unchanged. If a bit is set and cleared in the same cycle, it ends up set.
- R3: The MSI summary is bit 4 of the wrapper status register (`reg_addr` = 0). While armed, any set pulse latches that bit to 1 one cycle later.
- R4: Latching the summary bit disarms the wrapper. A vector set while disarmed stays pending in the vector register and does not raise bit 4.
- R5: A read (`reg_rd` = 1) of `reg_addr` = 1 that returns zero re-arms the wrapper. A set pulse in the same cycle as that zero read latches bit 4.
- R6: Bit k of the wrapper status (k = 0..3) latches on a 0-to-1 change of `intx_in[k]`. A line that stays high does not latch it again after it has been cleared.
- R7: Writing `reg_addr` = 0 clears every wrapper status bit whose `reg_wdata` bit is 1. A new latch event in the same cycle as the clear wins.
- R8: The enable register (`reg_addr` = 2, bits 4:0) reads back what was written, one bit per wrapper status bit. `irq_out` is 1 exactly when some wrapper status bit and its enable bit are both 1.
- R9: After reset, both status registers read zero, the enable register reads 0x1F, the wrapper is armed and `irq_out` is 0. A read of `reg_addr` = 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_set | input | 32 | Per-vector set pulses from the controller core |
| intx_in | input | 4 | Legacy INTx level inputs |
| reg_addr | input | 2 | Register select: 0 wrapper status, 1 vector status, 2 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a zero read of address 1 re-arms) |
| reg_wdata | input | 32 | Write data (write-one-to-clear for both status registers) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Interrupt to the system interrupt controller |

## Verification
The assertions assume that the register strobes and the address are stable within a cycle. They also assume that `intx_in` is a synchronous level, so a 0-to-1 change between two samples is a genuine edge. The bench drives every input at the falling clock edge, so each value is held across a full sampling window. Vector pulses in the random phase are sparse and single-bit, which keeps disarmed windows frequent. Directed steps place a set pulse on the same cycle as a clear, and on the same cycle as a zero read.

// File: rtl/msi_wrap_pkg.sv
`timescale 1ns/1ps
package msi_wrap_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_WSTAT = 2'd0,
    REG_VEC   = 2'd1,
    REG_EN    = 2'd2,
    REG_RSVD  = 2'd3
  } reg_addr_e;

  // Decide whether a bus access targets a given register.
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
    return reg_addr_e'(a) == r;
  endfunction
endpackage

// File: rtl/msi_vec_reg.sv
`timescale 1ns/1ps
module msi_vec_reg #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] vec_set,
  input  logic               clr_en,
  input  logic [NUM_VEC-1:0] clr_mask,
  output logic [NUM_VEC-1:0] vec_q,
  output logic               vec_zero
);
  // Write-one-to-clear with set taking priority.
  function automatic logic [NUM_VEC-1:0] vec_next(
    input logic [NUM_VEC-1:0] cur,
    input logic [NUM_VEC-1:0] clr,
    input logic [NUM_VEC-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  logic [NUM_VEC-1:0] clr_eff;

  always_comb clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_next(vec_q, clr_eff, vec_set);
  end

  always_comb vec_zero = (vec_q == '0);
endmodule

// File: rtl/msi_arm_ctrl.sv
`timescale 1ns/1ps
module msi_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_set,
  input  logic zero_read,
  output logic msi_event,
  output logic armed_q
);
  // A zero read in the same cycle counts as armed for an arriving pulse.
  always_comb msi_event = any_set && (armed_q || zero_read);

  always_ff @(posedge clk) begin
    if (!rst_n)          armed_q <= 1'b1;
    else if (msi_event)  armed_q <= 1'b0;
    else if (zero_read)  armed_q <= 1'b1;
  end
endmodule

// File: rtl/intx_edge.sv
`timescale 1ns/1ps
module intx_edge #(
  parameter int NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intx_in,
  output logic [NUM_INTX-1:0] intx_rise
);
  for (genvar k = 0; k < NUM_INTX; k++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= intx_in[k];
    end
    assign intx_rise[k] = intx_in[k] & ~prev_q;
  end
endmodule

// File: rtl/msi_latch_wrap.sv
`timescale 1ns/1ps
module msi_latch_wrap #(
  parameter int NUM_VEC  = 32,
  parameter int NUM_INTX = 4,
  parameter int DATA_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_VEC-1:0]            vec_set,
  input  logic [NUM_INTX-1:0]           intx_in,
  input  logic [msi_wrap_pkg::ADDR_W-1:0] reg_addr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          irq_out
);
  import msi_wrap_pkg::*;

  localparam int MSI_BIT = NUM_INTX;
  localparam int STAT_W  = NUM_INTX + 1;

  // Status update: write-one-to-clear, new events win.
  function automatic logic [STAT_W-1:0] stat_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  logic               wr_wstat, wr_vec, wr_en, rd_vec;
  logic [NUM_VEC-1:0] vec_q;
  logic               vec_zero;
  logic               zero_read;
  logic               msi_event;
  logic               armed_q;
  logic [NUM_INTX-1:0] intx_rise;
  logic [STAT_W-1:0]  wstat_q;
  logic [STAT_W-1:0]  en_q;
  logic [STAT_W-1:0]  wstat_clr;
  logic [STAT_W-1:0]  irq_src;

  always_comb begin
    wr_wstat = reg_wr && addr_hit(reg_addr, REG_WSTAT);
    wr_vec   = reg_wr && addr_hit(reg_addr, REG_VEC);
    wr_en    = reg_wr && addr_hit(reg_addr, REG_EN);
    rd_vec   = reg_rd && addr_hit(reg_addr, REG_VEC);
    zero_read = rd_vec && vec_zero;
  end

  msi_vec_reg #(.NUM_VEC(NUM_VEC)) vec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_set  (vec_set),
    .clr_en   (wr_vec),
    .clr_mask (reg_wdata[NUM_VEC-1:0]),
    .vec_q    (vec_q),
    .vec_zero (vec_zero)
  );

  msi_arm_ctrl arm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_set   (|vec_set),
    .zero_read (zero_read),
    .msi_event (msi_event),
    .armed_q   (armed_q)
  );

  intx_edge #(.NUM_INTX(NUM_INTX)) intx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .intx_in   (intx_in),
    .intx_rise (intx_rise)
  );

  always_comb wstat_clr = wr_wstat ? reg_wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wstat_q <= '0;
      en_q    <= '1;
    end else begin
      wstat_q <= stat_next(wstat_q, wstat_clr, {msi_event, intx_rise});
      if (wr_en) en_q <= reg_wdata[STAT_W-1:0];
    end
  end

  always_comb irq_src = wstat_q & en_q;
  always_comb irq_out = |irq_src;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      REG_WSTAT: reg_rdata[STAT_W-1:0]  = wstat_q;
      REG_VEC:   reg_rdata[NUM_VEC-1:0] = vec_q;
      REG_EN:    reg_rdata[STAT_W-1:0]  = en_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_latch_wrap_chk.sv
`timescale 1ns/1ps
module msi_latch_wrap_chk #(
  parameter int NUM_VEC  = 32,
  parameter int NUM_INTX = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_VEC-1:0]  vec_set,
  input logic [NUM_INTX-1:0] intx_in,
  input logic [NUM_VEC-1:0]  vec_q,
  input logic [NUM_INTX:0]   wstat_q,
  input logic                armed_q,
  input logic                zero_read,
  input logic                msi_event
);
  // R1 R2
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_set != '0) |=> ((vec_q & $past(vec_set)) == $past(vec_set)));

  // R3
  msi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wstat_q[NUM_INTX]) |-> $past(vec_set != '0));

  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_event |=> !armed_q);

  // R4
  no_latch_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !zero_read) |=> !$rose(wstat_q[NUM_INTX]));

  // R5
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_read && vec_set == '0) |=> armed_q);

  // R6
  intx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((intx_in & ~$past(intx_in)) != '0) |=> (wstat_q[NUM_INTX-1:0] != '0));
endmodule

bind msi_latch_wrap msi_latch_wrap_chk #(.NUM_VEC(NUM_VEC), .NUM_INTX(NUM_INTX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .vec_set   (vec_set),
  .intx_in   (intx_in),
  .vec_q     (vec_q),
  .wstat_q   (wstat_q),
  .armed_q   (armed_q),
  .zero_read (zero_read),
  .msi_event (msi_event)
);

// File: tb/msi_latch_wrap_tb_top.sv
`timescale 1ns/1ps
module msi_latch_wrap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vec_set = '0;
  logic [3:0]  intx_in = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  always #2.5 clk = ~clk;

  msi_latch_wrap dut_i (
    .clk(clk), .rst_n(rst_n), .vec_set(vec_set), .intx_in(intx_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference state, written from the requirements.
  logic [31:0] m_vec;
  logic [4:0]  m_ws, m_en;
  logic        m_arm;
  logic [3:0]  m_prev;
  logic [3:0]  cur_ix = '0;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {27'd0, m_ws};
      2'd1: return m_vec;
      2'd2: return {27'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_ws & m_en);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_vec = '0; m_ws = '0; m_en = 5'h1F; m_arm = 1'b1; m_prev = '0;
  endtask

  // One cycle, entered and left at a falling edge.
  task automatic cyc(input logic [31:0] vs, input logic [1:0] a, input bit wr,
                     input bit rd, input logic [31:0] wd, input string tag);
    logic zr, ev;
    logic [3:0] rise;
    logic [31:0] clrv;
    logic [4:0] clrw;
    vec_set = vs; intx_in = cur_ix; reg_addr = a; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
    #1;
    if (rd) check(reg_rdata, exp_read(a), tag);
    zr   = rd && a == 2'd1 && m_vec == '0;
    ev   = (vs != '0) && (m_arm || zr);
    rise = cur_ix & ~m_prev;
    clrv = (wr && a == 2'd1) ? wd : '0;
    clrw = (wr && a == 2'd0) ? wd[4:0] : '0;
    @(posedge clk);
    m_vec  = (m_vec & ~clrv) | vs;
    m_ws   = (m_ws & ~clrw) | {ev, rise};
    if (wr && a == 2'd2) m_en = wd[4:0];
    m_arm  = ev ? 1'b0 : (zr ? 1'b1 : m_arm);
    m_prev = cur_ix;
    @(negedge clk);
    vec_set = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    check({31'd0, irq_out}, {31'd0, exp_irq()}, "R8 irq");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc('0, a, 1'b0, 1'b1, '0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    cyc('0, a, 1'b1, 1'b0, d, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    #1 check({31'd0, irq_out}, 32'd0, "R9 irq after reset");
    rd(2'd0, "R9 wstat reset");
    rd(2'd1, "R9 vec reset");
    rd(2'd2, "R9 enable reset");
    rd(2'd3, "R9 reserved reads zero");
    // R3 first vector latches summary
    cyc(32'h8, 2'd0, 0, 0, '0, "R3");
    rd(2'd0, "R3 msi summary at bit 4");
    rd(2'd1, "R1 vector 3 pending");
    wr(2'd0, 32'h10, "R7");
    rd(2'd0, "R7 summary cleared");
    // R4 disarmed: vector stays pending, no summary
    cyc(32'h20, 2'd0, 0, 0, '0, "R4");
    rd(2'd0, "R4 no summary while disarmed");
    rd(2'd1, "R4 nonzero read keeps disarmed");
    // R2 set wins over clear in the same cycle
    cyc(32'h200, 2'd1, 1, 0, 32'h228, "R2");
    rd(2'd1, "R2 set beats clear");
    rd(2'd0, "R4 still no summary");
    wr(2'd1, 32'h200, "R2");
    rd(2'd1, "R5 zero read arms");
    cyc(32'h80, 2'd0, 0, 0, '0, "R5");
    rd(2'd0, "R5 latch after rearm");
    wr(2'd0, 32'h10, "R7");
    wr(2'd1, 32'h80, "R2");
    // R5 pulse in the same cycle as the zero read
    cyc(32'h2, 2'd1, 0, 1, '0, "R5 zero read with pulse");
    rd(2'd0, "R5 same-cycle pulse latched");
    wr(2'd0, 32'h10, "R7");
    wr(2'd1, 32'h2, "R2");
    rd(2'd1, "R5 rearm");
    // R6 and R7: INTx rise with a same-cycle clear
    cur_ix = 4'b0001;
    cyc('0, 2'd0, 1, 0, 32'h1, "R7 rise beats clear");
    rd(2'd0, "R7 bit0 held");
    wr(2'd0, 32'h1, "R6");
    rd(2'd0, "R6 level high does not relatch");
    cur_ix = 4'b0100;
    cyc('0, 2'd0, 0, 0, '0, "R6");
    rd(2'd0, "R6 bit2 latched on rise");
    // R8 enable masking
    wr(2'd2, 32'h0, "R8");
    rd(2'd2, "R8 enable readback");
    wr(2'd2, 32'h04, "R8");
    rd(2'd2, "R8 enable readback one bit");
    wr(2'd2, 32'h1F, "R8");
    wr(2'd0, 32'h1F, "R7");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] vs, wd;
      logic [1:0] a;
      int op;
      vs = ($urandom % 6 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
      if ($urandom % 10 == 0) cur_ix = 4'($urandom);
      a  = 2'($urandom % 4);
      op = $urandom % 10;
      if (op < 2) begin
        wd = ($urandom % 2 == 0) ? exp_read(a) : $urandom;
        if (a == 2'd2 && ($urandom % 2 == 0)) wd = 32'h1F;
        cyc(vs, a, 1, 0, wd, "R1 R2 R3 R4 R5 R6 R7 random");
      end else if (op < 6) begin
        cyc(vs, a, 0, 1, '0, "R1 R3 R4 R5 R6 R8 random read");
      end else begin
        cyc(vs, a, 0, 0, '0, "R3 R4 random idle");
      end
    end
    finish_run();
  end
endmodule